// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on a single line. The host writes a character into a one-entry holding buffer. When the shift stage is free, the character moves into it, which frees the buffer for the next write. Because of this hand-over, a second character can wait while the first one is still shifting. Frames then follow each other with no idle time between the last stop bit of one and the start bit of the next.

The bit period comes from a divider clocked by a count-clock enable. The divider counts the divisor value plus one, sixteen times over. A frame is made of these parts, in order:
- a low start bit;
- 7, 8 or 9 data bits, least significant first;
- an optional even or odd parity bit;
- one or two high stop bits.

Three flags report state: buffer empty, shift stage empty, and a latched interrupt request. A select input chooses the interrupt event. The request is raised either when the buffer is handed to the shift stage or when the line falls idle after a frame. Software clears the request with a clear pulse.

Top module: `uart_dbuf_tx`

## Requirements
- R1: One bit period lasts 16 × (divisor + 1) cycles in which `cnt_tick` is 1. The divisor is read again at every bit boundary. The first bit period of a frame starts counting afresh at the cycle the frame is loaded.
- R2: A frame is a low start bit, then the data bits least significant first, then the parity bit when present, then the stop bits. The `len_code` input sets the data length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 also gives 8 bits.
- R3: With 9-bit data, bit 8 is sent right after bit 7, in the slot parity would use, and `par_en` is ignored.
- R4: With `par_en`=1 and 7 or 8 data bits, one parity bit follows the data. It is the XOR of the sent data bits when `par_odd`=0 (even parity) and the inverse of that XOR when `par_odd`=1 (odd parity).
- R5: `two_stop`=0 gives one high stop period and `two_stop`=1 gives two.
- R6: A cycle with `wr_en`=1 makes `buf_empty` 0 on the next cycle. A write while the buffer is full replaces the waiting character.
- R7: When `tx_en`=1, the buffer is full and the shift stage is free, the character moves in at the next clock edge. At that edge `buf_empty` becomes 1, `shift_empty` becomes 0 and the start bit begins.
- R8: If the buffer is full and `tx_en`=1 when the last stop bit ends, the next start bit follows at once and `shift_empty` stays 0.
- R9: `shift_empty` returns to 1 when the last stop bit ends and no frame follows. `txd` is 1 whenever `shift_empty` is 1.
- R10: With `irq_sel`=0, `irq` is set at the edge where the buffer is handed over. With `irq_sel`=1, `irq` is set at the edge where `shift_empty` rises.
- R11: `irq` stays at 1 until a cycle with `irq_clr`=1. If a new event arrives in the same cycle as the clear, the event wins.
- R12: While `tx_en`=0 no frame starts and a waiting character stays in the buffer. A frame already in flight runs to its end, because the divider keeps running while a frame is shifting. After that frame the line stays high.
- R13: After reset, `txd`=1, `buf_empty`=1, `shift_empty`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count-clock enable for the divider |
| tx_en | input | 1 | Transmit enable |
| divisor | input | DIV_W (8) | Divider value n; bit period is 16 × (n + 1) ticks |
| len_code | input | 2 | Data length select: 0 = 7 bits, 1 or 3 = 8 bits, 2 = 9 bits |
| par_en | input | 1 | Parity enable (7 and 8 bit data only) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| irq_sel | input | 1 | 0 = interrupt on buffer hand-over, 1 = interrupt on line idle |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 9 | Character to write |
| irq_clr | input | 1 | Clears the latched interrupt request |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | No frame is shifting |
| irq | output | 1 | Latched interrupt request |

## Verification
The assertions take for granted several things about the inputs:
- the format inputs and the divisor are only changed while the line is idle, or are at least steady across a load;
- reset is held for more than one clock;
- `cnt_tick` is a plain enable with no other timing meaning.

The stimulus sets the format and the divisor between frames only, and raises writes and clears at falling clock edges. It holds `cnt_tick` at 1, so each bit lasts a known 16 × (n + 1) clock cycles, and it samples the line in the middle of each bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_MAX = 9;
  localparam int FRAME_W  = 12;
  localparam int LEN_W    = 4;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [LEN_W-1:0]   flen_t;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fmt_t;

  function automatic flen_t data_bits(logic [1:0] code);
    case (code)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic has_parity(fmt_t f);
    return f.par_en && (data_bits(f.len_code) != 4'd9);
  endfunction

  function automatic logic parity_of(logic [DATA_MAX-1:0] d, flen_t nb, logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < int'(nb)) p = p ^ d[i];
    return p;
  endfunction

  function automatic flen_t frame_len(fmt_t f);
    return 4'd1 + data_bits(f.len_code) + {3'b000, has_parity(f)}
           + (f.two_stop ? 4'd2 : 4'd1);
  endfunction

  // Frame image, bit 0 goes out first; unused upper positions stay high.
  function automatic frame_t build_frame(logic [DATA_MAX-1:0] d, fmt_t f);
    frame_t fr;
    flen_t  nb;
    nb    = data_bits(f.len_code);
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < int'(nb)) fr[i+1] = d[i];
    if (has_parity(f)) fr[int'(nb)+1] = parity_of(d, nb, f.par_odd);
    return fr;
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_tick
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [SUB_W-1:0] sub_cnt;

  assign bit_tick = run && tick && (div_cnt == '0) && (sub_cnt == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sub_cnt <= '0;
    end else if (!run || restart) begin
      div_cnt <= divisor;
      sub_cnt <= '0;
    end else if (tick) begin
      if (div_cnt == '0) begin
        div_cnt <= divisor;
        sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else begin
      buf_full <= wr_en || (buf_full && !take);
      if (wr_en) buf_data <= wr_data;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t frame_in,
  input  flen_t  len_in,
  input  logic   bit_tick,
  output logic   txd,
  output logic   busy,
  output logic   frame_end
);
  frame_t sreg;
  flen_t  left;

  assign frame_end = busy && bit_tick && (left == '0);
  assign txd       = busy ? sreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sreg <= frame_in;
      left <= len_in - 1'b1;
      busy <= 1'b1;
    end else if (busy && bit_tick) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        sreg <= {1'b1, sreg[FRAME_W-1:1]};
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_tick,
  input  logic                tx_en,
  input  logic [DIV_W-1:0]    divisor,
  input  logic [1:0]          len_code,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                irq_sel,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic                irq_clr,
  output logic                txd,
  output logic                buf_empty,
  output logic                shift_empty,
  output logic                irq
);
  logic                buf_full;
  logic [DATA_MAX-1:0] buf_data;
  logic                busy;
  logic                frame_end;
  logic                bit_tick;
  logic                load_evt;
  logic                xmit_done;
  logic                irq_evt;
  fmt_t                fmt;

  assign fmt       = '{len_code: len_code, par_en: par_en, par_odd: par_odd, two_stop: two_stop};
  assign load_evt  = tx_en && buf_full && (!busy || frame_end);
  assign xmit_done = frame_end && !load_evt;
  assign irq_evt   = irq_sel ? xmit_done : load_evt;

  uart_tx_holdbuf #(.DATA_W(DATA_MAX)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load_evt), .buf_data(buf_data), .buf_full(buf_full)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(tx_en || busy), .restart(load_evt),
    .tick(cnt_tick), .divisor(divisor), .bit_tick(bit_tick)
  );

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .frame_in(build_frame(buf_data, fmt)), .len_in(frame_len(fmt)),
    .bit_tick(bit_tick), .txd(txd), .busy(busy), .frame_end(frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_evt) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assign buf_empty   = !buf_full;
  assign shift_empty = !busy;
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic irq_sel,
  input logic irq_clr,
  input logic wr_en,
  input logic txd,
  input logic buf_empty,
  input logic shift_empty,
  input logic irq,
  input logic bit_tick,
  input logic load_evt,
  input logic xmit_done
);
  assert_line_moves_on_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick || load_evt));

  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);

  assert_handover_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !shift_empty);

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  assert_idle_only_when_nothing_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_empty) |-> $past(buf_empty || !tx_en));

  assert_irq_on_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !irq_sel) |=> irq);

  assert_irq_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_done && irq_sel) |=> irq);

  assert_irq_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_falls_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  assert_no_start_when_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && shift_empty) |=> shift_empty);
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_sel(irq_sel), .irq_clr(irq_clr),
  .wr_en(wr_en), .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty),
  .irq(irq), .bit_tick(bit_tick), .load_evt(load_evt), .xmit_done(xmit_done)
);

// File: tb/uart_dbuf_tx_bench.sv
module uart_dbuf_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b1;
  logic       tx_en = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic [1:0] len_code = 2'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       irq_sel = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd, buf_empty, shift_empty, irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_dbuf_tx u_uart_dbuf_tx (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .tx_en(tx_en), .divisor(divisor),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .irq_sel(irq_sel), .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr),
    .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
  );

  // {data[8:0], len_code[1:0], par_en, par_odd, two_stop, divisor[7:0]}
  localparam int NVEC = 7;
  localparam logic [21:0] VECS [NVEC] = '{
    {9'h0A5, 2'd1, 1'b0, 1'b0, 1'b0, 8'd0},
    {9'h053, 2'd0, 1'b1, 1'b0, 1'b1, 8'd1},
    {9'h0C3, 2'd1, 1'b1, 1'b1, 1'b0, 8'd0},
    {9'h1A6, 2'd2, 1'b1, 1'b0, 1'b1, 8'd0},
    {9'h0FF, 2'd1, 1'b0, 1'b0, 1'b1, 8'd2},
    {9'h12E, 2'd2, 1'b0, 1'b0, 1'b0, 8'd1},
    {9'h07F, 2'd3, 1'b1, 1'b0, 1'b0, 8'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return (len_code == 2'd0) ? 7 : (len_code == 2'd2) ? 9 : 8;
  endfunction

  function automatic int exp_len();
    int n = nbits();
    return 1 + n + ((par_en && n != 9) ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

  function automatic logic exp_bit(logic [8:0] d, int k);
    int n = nbits();
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= n) return d[k-1];
    if (k == n + 1 && par_en && n != 9) begin
      for (int i = 0; i < n; i++) ones += int'(d[i]);
      return (ones % 2 == 1) ? !par_odd : par_odd;
    end
    return 1'b1;
  endfunction

  // Starts half a cycle after the load edge, ends half a cycle after frame end.
  task automatic sample_frame(string req, logic [8:0] d);
    int t = 16 * (int'(divisor) + 1);
    int h = t / 2;
    for (int k = 0; k < exp_len(); k++) begin
      repeat (h) @(negedge clk);
      chk(req, 32'(txd), 32'(exp_bit(d, k)));
      repeat (t - h) @(negedge clk);
    end
  endtask

  task automatic write_buf(logic [8:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  function automatic string tag_of();
    if (len_code == 2'd2) return "R3";
    if (par_en) return "R4";
    if (two_stop) return "R5";
    return "R2";
  endfunction

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", 32'(txd), 1); chk("R13", 32'(buf_empty), 1);
    chk("R13", 32'(shift_empty), 1); chk("R13", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tx_en = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      {len_code, par_en, par_odd, two_stop, divisor} = VECS[v][12:0];
      write_buf(VECS[v][21:13]);
      @(negedge clk);
      chk("R7", 32'(buf_empty), 1); chk("R7", 32'(shift_empty), 0);
      sample_frame(tag_of(), VECS[v][21:13]);
      chk("R9", 32'(shift_empty), 1); chk("R9", 32'(txd), 1);
    end

    // R1: start bit lasts 16*(1+1) cycles
    {len_code, par_en, two_stop, divisor} = {2'd1, 1'b0, 1'b0, 8'd1};
    write_buf(9'h001);
    @(negedge clk);
    cnt = 0;
    while (txd == 1'b0 && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R1", 32'(cnt), 32);
    cnt = 0;
    while (!shift_empty && cnt < 2000) begin cnt++; @(negedge clk); end
    divisor = 8'd0;

    // R6 and R12: writes while disabled, last one kept
    tx_en = 1'b0;
    write_buf(9'h011);
    chk("R6", 32'(buf_empty), 0);
    write_buf(9'h05A);
    repeat (100) @(negedge clk);
    chk("R12", 32'(txd), 1); chk("R12", 32'(shift_empty), 1); chk("R12", 32'(buf_empty), 0);
    tx_en = 1'b1;
    @(negedge clk);
    sample_frame("R6", 9'h05A);

    // R8: back to back frames
    @(negedge clk); wr_en = 1'b1; wr_data = 9'h0F0;
    @(negedge clk); wr_data = 9'h00F;
    @(negedge clk); wr_en = 1'b0;
    chk("R8", 32'(buf_empty), 0);
    sample_frame("R8", 9'h0F0);
    chk("R8", 32'(shift_empty), 0);
    sample_frame("R8", 9'h00F);
    chk("R8", 32'(shift_empty), 1);

    // R10 select 0: request on hand-over
    irq_sel = 1'b0;
    pulse_clr();
    chk("R11", 32'(irq), 0);
    write_buf(9'h0AA);
    @(negedge clk);
    chk("R10", 32'(irq), 1);
    pulse_clr();
    chk("R11", 32'(irq), 0);
    cnt = 0;
    while (!shift_empty && cnt < 2000) begin cnt++; @(negedge clk); end
    chk("R10", 32'(irq), 0);

    // R10 select 1: request when the line falls idle
    irq_sel = 1'b1;
    write_buf(9'h03C);
    @(negedge clk);
    chk("R10", 32'(irq), 0);
    sample_frame("R2", 9'h03C);
    chk("R10", 32'(irq), 1);
    repeat (20) @(negedge clk);
    chk("R11", 32'(irq), 1);
    pulse_clr();
    chk("R11", 32'(irq), 0);

    // R11: event wins over a clear in the same cycle
    irq_sel = 1'b0;
    write_buf(9'h055);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R11", 32'(irq), 1);
    cnt = 0;
    while (!shift_empty && cnt < 2000) begin cnt++; @(negedge clk); end

    // R12: disabling mid-frame finishes the frame, then holds the next
    @(negedge clk); wr_en = 1'b1; wr_data = 9'h0C5;
    @(negedge clk); wr_data = 9'h03A;
    @(negedge clk); wr_en = 1'b0; tx_en = 1'b0;
    sample_frame("R12", 9'h0C5);
    chk("R12", 32'(shift_empty), 1); chk("R12", 32'(buf_empty), 0);
    repeat (50) @(negedge clk);
    chk("R12", 32'(txd), 1);
    tx_en = 1'b1;
    @(negedge clk);
    sample_frame("R12", 9'h03A);
    chk("R12", 32'(shift_empty), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule